// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block sits between a cache miss path and a single-channel, single-rank DRAM with a parameterised number of banks. It takes read requests as a 32-bit byte address plus a tag, holds them in a four-entry pending queue, and decides which request goes to the memory next. Requests that find their row already open in an idle bank go first. Within the same class, the oldest request goes first. Consecutive issues are kept at least ten cycles apart.

Each bank keeps its open row and a busy countdown. A row hit takes 50 cycles. A row conflict or an access to a closed bank takes 250 cycles. Banks work in parallel, and each bank serves one request at a time. When a bank finishes, its tag is returned on a one-per-cycle completion port. The per-bank busy and row-open flags are brought out for observation.

Top module: `frfcfs_sched`

## Requirements
- R1: The address splits as follows: bits [5:0] are the line offset, bits [11:6] are the column, the next log2(NBANK) bits (bits [14:12] with 8 banks) are the bank, and all bits above that are the row. Only the bank and row fields affect scheduling and latency.
- R2: After reset all row buffers are closed and no bank is busy. `bank_open` and `bank_busy` are all zero, `req_ready` is 1 and `cpl_valid` is 0.
- R3: An access to a bank with no open row finishes 250 cycles after issue, and it leaves that row open.
- R4: An access whose row equals the open row of its bank finishes 50 cycles after issue. If it is not delayed, its tag appears on `cpl_valid`/`cpl_tag` in the cycle after clock edge issue+50.
- R5: An access to a row other than the open one finishes 250 cycles after issue, and it replaces the open row.
- R6: When an issue slot is free, a queued row hit to an idle bank is issued before any older request that is not a hit.
- R7: Among eligible requests of equal class (all hits, or no hits at all), the one accepted earliest is issued first.
- R8: Two issues are at least 10 clock edges apart. A request accepted into an empty queue, with its bank idle and the spacing window expired, issues on the next edge.
- R9: A bank holds at most one request in service, and `bank_busy` is high from issue until its completion is reported. Requests to different banks are in service at the same time.
- R10: The queue holds 4 requests. `req_ready` is low while all 4 entries are occupied, and no request is taken until an entry leaves.
- R11: If several banks finish in the same cycle, the lowest-indexed bank is reported first. Each other bank is held and reported in a following cycle, one per cycle.
- R12: Each completion returns the tag given with its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_addr | input | 32 | Request byte address |
| req_tag | input | TAG_W | Request identifier |
| req_ready | output | 1 | Queue can take a request this cycle |
| cpl_valid | output | 1 | A request finished |
| cpl_tag | output | TAG_W | Tag of the finished request |
| bank_busy | output | NBANK | Bank has a request in service or awaiting report |
| bank_open | output | NBANK | Bank has an open row |

## Verification
The bench goes after the following corner cases:

- **Young hit beside an older conflict to the same bank.** A scheduler that stays strictly first-come would serve the conflict first. That shifts the hit's completion by about 250 cycles.
- **Two hits waiting behind the spacing window.** A scheduler that mishandles age would reverse them.
- **A 50-cycle hit timed to finish on the same cycle as an earlier 250-cycle miss in a higher bank.** A broken completion arbiter would drop one tag or report them in the wrong order.
- **Full queue while the only bank is busy.** This exposes a `req_ready` that reopens early.
- **Addresses that differ only in column and offset.** A decoder that used the wrong bits would turn the expected hit into a 250-cycle conflict.

// File: rtl/frfcfs_pkg.sv
// Shared constants for the row-hit-first scheduler.
// Assumes a byte-addressed 32-bit space with 64-byte lines and 64 lines per row.
package frfcfs_pkg;
    localparam int ADDR_W   = 32;
    localparam int OFF_W    = 6;
    localparam int COL_W    = 6;
    localparam int BANK_LSB = OFF_W + COL_W;

    // Latency class chosen at issue time
    typedef enum logic {
        ACC_HIT  = 1'b1,
        ACC_SLOW = 1'b0
    } acc_kind_e;
endpackage

// File: rtl/frfcfs_queue.sv
// Pending request queue with row-hit-first, oldest-first selection.
// Each entry keeps its bank, row, tag and an age rank (0 = oldest).
// Assumes enq_vld is only raised while full is low.
module frfcfs_queue #(
    parameter int QDEPTH = 4,
    parameter int NBANK  = 8,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 17,
    parameter int TAG_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_vld,
    input  logic [BANK_W-1:0]             enq_bank,
    input  logic [ROW_W-1:0]              enq_row,
    input  logic [TAG_W-1:0]              enq_tag,
    input  logic                          issue_en,
    input  logic [NBANK-1:0]              bank_busy,
    input  logic [NBANK-1:0]              open_vld,
    input  logic [NBANK-1:0][ROW_W-1:0]   open_row,
    output logic                          full,
    output logic                          iss_vld,
    output logic [BANK_W-1:0]             iss_bank,
    output logic [ROW_W-1:0]              iss_row,
    output logic [TAG_W-1:0]              iss_tag,
    output logic                          iss_hit
);
    localparam int QIDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int CNT_W  = $clog2(QDEPTH + 1);

    logic [QDEPTH-1:0]              q_vld;
    logic [QDEPTH-1:0][BANK_W-1:0]  q_bank;
    logic [QDEPTH-1:0][ROW_W-1:0]   q_row;
    logic [QDEPTH-1:0][TAG_W-1:0]   q_tag;
    logic [QDEPTH-1:0][QIDX_W-1:0]  q_age;

    logic [QDEPTH-1:0] elig, hit, cand;
    logic [QIDX_W-1:0] sel, free_idx;
    logic              found;
    logic [CNT_W-1:0]  cnt;

    // Classify entries: eligible when the bank is idle, a hit when the open row matches
    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            elig[i] = q_vld[i] && !bank_busy[q_bank[i]];
            hit[i]  = elig[i] && open_vld[q_bank[i]] && (open_row[q_bank[i]] == q_row[i]);
        end
        cand = (|hit) ? hit : elig;
    end

    // Pick the oldest candidate
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (cand[i] && (!found || q_age[i] < q_age[sel])) begin
                sel   = QIDX_W'(i);
                found = 1'b1;
            end
        end
    end

    // Lowest free slot and occupancy count
    always_comb begin
        free_idx = '0;
        for (int i = QDEPTH - 1; i >= 0; i--) begin
            if (!q_vld[i]) free_idx = QIDX_W'(i);
        end
        cnt = CNT_W'($countones(q_vld));
    end

    assign full     = &q_vld;
    assign iss_vld  = found && issue_en;
    assign iss_bank = q_bank[sel];
    assign iss_row  = q_row[sel];
    assign iss_tag  = q_tag[sel];
    assign iss_hit  = |hit;

    // Remove the issued entry, close the age gap, insert the new request as youngest
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_vld  <= '0;
            q_bank <= '0;
            q_row  <= '0;
            q_tag  <= '0;
            q_age  <= '0;
        end else begin
            for (int i = 0; i < QDEPTH; i++) begin
                if (iss_vld && sel == QIDX_W'(i)) begin
                    q_vld[i] <= 1'b0;
                end else if (q_vld[i] && iss_vld && q_age[i] > q_age[sel]) begin
                    q_age[i] <= q_age[i] - 1'b1;
                end
            end
            if (enq_vld) begin
                q_vld[free_idx]  <= 1'b1;
                q_bank[free_idx] <= enq_bank;
                q_row[free_idx]  <= enq_row;
                q_tag[free_idx]  <= enq_tag;
                q_age[free_idx]  <= QIDX_W'(cnt - (iss_vld ? CNT_W'(1) : CNT_W'(0)));
            end
        end
    end

    AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld |-> !bank_busy[iss_bank]); // R9

    for (genvar g = 0; g < QDEPTH; g++) begin : g_age_chk
        AST_AGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            q_vld[g] |-> (CNT_W'(q_age[g]) < cnt)); // R7
    end
endmodule

// File: rtl/frfcfs_bank.sv
// One DRAM bank model: tracks the open row and counts down the service latency.
// When the countdown ends, fin stays high until the completion arbiter grants it.
// Assumes start is only raised while busy is low.
module frfcfs_bank #(
    parameter int ROW_W    = 17,
    parameter int TAG_W    = 4,
    parameter int HIT_LAT  = 50,
    parameter int MISS_LAT = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_hit,
    input  logic [ROW_W-1:0] start_row,
    input  logic [TAG_W-1:0] start_tag,
    input  logic             grant,
    output logic             busy,
    output logic             fin,
    output logic [TAG_W-1:0] tag,
    output logic             open_vld,
    output logic [ROW_W-1:0] open_row
);
    import frfcfs_pkg::*;

    localparam int MAX_LAT = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT + 1);

    logic [LAT_W-1:0] cnt;
    acc_kind_e        kind;

    assign kind = start_hit ? ACC_HIT : ACC_SLOW;
    assign fin  = busy && (cnt == '0);

    // Load latency on issue, count down, release once the completion is reported
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            tag      <= '0;
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            cnt      <= (kind == ACC_HIT) ? LAT_W'(HIT_LAT - 1) : LAT_W'(MISS_LAT - 1);
            tag      <= start_tag;
            open_vld <= 1'b1;
            open_row <= start_row;
        end else if (busy) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else if (grant) begin
                busy <= 1'b0;
            end
        end
    end

    AST_BANK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9
    AST_ROW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (open_vld && open_row == $past(start_row))); // R3
    AST_FIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !grant) |=> fin); // R11
endmodule

// File: rtl/frfcfs_cpl_arb.sv
// Completion reporter: grants the lowest-indexed finished bank each cycle
// and registers its tag onto the completion port.
module frfcfs_cpl_arb #(
    parameter int NBANK = 8,
    parameter int TAG_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NBANK-1:0]             fin,
    input  logic [NBANK-1:0][TAG_W-1:0]  fin_tag,
    output logic [NBANK-1:0]             grant,
    output logic                         cpl_valid,
    output logic [TAG_W-1:0]             cpl_tag
);
    logic [TAG_W-1:0] win_tag;

    // Fixed priority, lowest index wins
    always_comb begin
        grant   = '0;
        win_tag = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (fin[i]) begin
                grant   = '0;
                grant[i] = 1'b1;
                win_tag = fin_tag[i];
            end
        end
    end

    // Register the reported completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid <= 1'b0;
            cpl_tag   <= '0;
        end else begin
            cpl_valid <= |fin;
            cpl_tag   <= win_tag;
        end
    end

    AST_CPL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|fin) |=> cpl_valid); // R12
    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|fin) == (|grant))); // R11
endmodule

// File: rtl/frfcfs_sched.sv
// Row-hit-first DRAM request scheduler (top).
// Decodes bank and row from the byte address, queues requests, enforces
// issue spacing and drives one bank model per bank. Assumes NBANK is a
// power of two of at least 2 and ISSUE_GAP is at least 1.
module frfcfs_sched #(
    parameter int NBANK     = 8,
    parameter int QDEPTH    = 4,
    parameter int TAG_W     = 4,
    parameter int HIT_LAT   = 50,
    parameter int MISS_LAT  = 250,
    parameter int ISSUE_GAP = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [31:0]      req_addr,
    input  logic [TAG_W-1:0] req_tag,
    output logic             req_ready,
    output logic             cpl_valid,
    output logic [TAG_W-1:0] cpl_tag,
    output logic [NBANK-1:0] bank_busy,
    output logic [NBANK-1:0] bank_open
);
    import frfcfs_pkg::*;

    localparam int BANK_W  = $clog2(NBANK);
    localparam int ROW_LSB = BANK_LSB + BANK_W;
    localparam int ROW_W   = ADDR_W - ROW_LSB;
    localparam int GAP_W   = $clog2(ISSUE_GAP + 1);

    logic                        q_full, iss_vld, iss_hit, enq_vld, issue_en;
    logic [BANK_W-1:0]           iss_bank;
    logic [ROW_W-1:0]            iss_row;
    logic [TAG_W-1:0]            iss_tag;
    logic [NBANK-1:0][ROW_W-1:0] open_row;
    logic [NBANK-1:0][TAG_W-1:0] bank_tag;
    logic [NBANK-1:0]            bank_fin, bank_grant;
    logic [GAP_W-1:0]            gap_cnt;

    assign req_ready = !q_full;
    assign enq_vld   = req_valid && !q_full;
    assign issue_en  = (gap_cnt == '0);

    // Spacing window between consecutive issues
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (iss_vld) begin
            gap_cnt <= GAP_W'(ISSUE_GAP - 1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    frfcfs_queue #(
        .QDEPTH(QDEPTH), .NBANK(NBANK), .BANK_W(BANK_W),
        .ROW_W(ROW_W), .TAG_W(TAG_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .enq_vld  (enq_vld),
        .enq_bank (req_addr[BANK_LSB +: BANK_W]),
        .enq_row  (req_addr[ADDR_W-1:ROW_LSB]),
        .enq_tag  (req_tag),
        .issue_en (issue_en),
        .bank_busy(bank_busy),
        .open_vld (bank_open),
        .open_row (open_row),
        .full     (q_full),
        .iss_vld  (iss_vld),
        .iss_bank (iss_bank),
        .iss_row  (iss_row),
        .iss_tag  (iss_tag),
        .iss_hit  (iss_hit)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        frfcfs_bank #(
            .ROW_W(ROW_W), .TAG_W(TAG_W),
            .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (iss_vld && iss_bank == BANK_W'(b)),
            .start_hit(iss_hit),
            .start_row(iss_row),
            .start_tag(iss_tag),
            .grant    (bank_grant[b]),
            .busy     (bank_busy[b]),
            .fin      (bank_fin[b]),
            .tag      (bank_tag[b]),
            .open_vld (bank_open[b]),
            .open_row (open_row[b])
        );
    end

    frfcfs_cpl_arb #(.NBANK(NBANK), .TAG_W(TAG_W)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (bank_fin),
        .fin_tag  (bank_tag),
        .grant    (bank_grant),
        .cpl_valid(cpl_valid),
        .cpl_tag  (cpl_tag)
    );

    AST_ISSUE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && ISSUE_GAP > 1) |=> !iss_vld); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && !iss_vld) |=> q_full); // R10
    AST_ADDR_DEFINED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$isunknown(req_addr)); // R1
endmodule

// File: tb/frfcfs_sched_test.sv
// Directed bench for the row-hit-first scheduler: one task per scenario.
module frfcfs_sched_test;
    localparam int NB = 8;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic [TW-1:0] req_tag = '0;
    logic          req_ready, cpl_valid;
    logic [TW-1:0] cpl_tag;
    logic [NB-1:0] bank_busy, bank_open;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int log_tag [64];
    int log_cyc [64];
    int n_log = 0;

    frfcfs_sched uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_tag(req_tag), .req_ready(req_ready), .cpl_valid(cpl_valid),
        .cpl_tag(cpl_tag), .bank_busy(bank_busy), .bank_open(bank_open)
    );

    always #10 clk = ~clk;

    // Count edges
    always @(posedge clk) cyc <= cyc + 1;

    // Log completions with the edge after which they appeared
    always @(negedge clk) begin
        if (rst_n && cpl_valid && n_log < 64) begin
            log_tag[n_log] = int'(cpl_tag);
            log_cyc[n_log] = cyc;
            n_log++;
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog
    initial begin
        #(20 * 40000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    function automatic logic [31:0] mk(int bank, int row, int col, int off);
        return {row[16:0], bank[2:0], col[5:0], off[5:0]};
    endfunction

    task automatic chk(int act, int exp, string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_log = 0;
    endtask

    // Offer one request, hold until taken; returns the accepting edge
    task automatic push(int bank, int row, int col, int tag, output int acc);
        logic rdy;
        req_valid = 1'b1;
        req_addr  = mk(bank, row, col, 5);
        req_tag   = TW'(tag);
        forever begin
            rdy = req_ready;
            @(negedge clk);
            if (rdy) break;
        end
        acc = cyc;
        req_valid = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_cpl(int tag, int exp_cyc, string req);
        int got = -1;
        for (int i = 0; i < n_log; i++) if (log_tag[i] == tag) got = log_cyc[i];
        chk(got, exp_cyc, req);
    endtask

    task automatic t_reset();
        do_reset();
        chk(int'(req_ready), 1, "R2 ready");
        chk(int'(cpl_valid), 0, "R2 cpl_valid");
        chk(int'(bank_busy), 0, "R2 busy");
        chk(int'(bank_open), 0, "R2 open");
    endtask

    task automatic t_latency();
        int a, b, c;
        do_reset();
        push(0, 5, 3, 1, a);
        @(negedge clk);
        chk(int'(bank_busy[0]), 1, "R9 busy after issue");
        wait_to(a + 260);
        expect_cpl(1, a + 251, "R3 closed bank latency");
        chk(int'(bank_busy[0]), 0, "R9 busy clears");
        chk(int'(bank_open[0]), 1, "R3 row left open");
        push(0, 5, 40, 2, b);
        wait_to(b + 60);
        expect_cpl(2, b + 51, "R4 hit latency, R1 column ignored");
        push(0, 6, 3, 3, c);
        wait_to(c + 260);
        expect_cpl(3, c + 251, "R5 conflict latency");
    endtask

    task automatic t_hit_first();
        int a, p, o, h;
        do_reset();
        push(1, 7, 0, 1, a);
        wait_to(a + 260);
        push(3, 0, 0, 2, p);
        push(1, 9, 0, 3, o);
        push(1, 7, 9, 4, h);
        wait_to(p + 320);
        expect_cpl(4, p + 61, "R6 young hit first");
        expect_cpl(2, p + 251, "R9 parallel bank");
        expect_cpl(3, p + 312, "R6 older conflict later");
    endtask

    task automatic t_oldest();
        int a, b, p, y, z;
        do_reset();
        push(4, 1, 0, 1, a);
        push(5, 2, 0, 2, b);
        wait_to(b + 270);
        push(6, 0, 0, 3, p);
        push(5, 2, 1, 4, y);
        push(4, 1, 1, 5, z);
        wait_to(p + 260);
        expect_cpl(4, p + 61, "R7 older hit first");
        expect_cpl(5, p + 71, "R7 younger hit next");
        expect_cpl(3, p + 251, "R8 immediate issue");
    endtask

    task automatic t_spacing();
        int a, t;
        do_reset();
        push(0, 2, 0, 1, a);
        push(1, 2, 0, 2, t);
        push(2, 2, 0, 3, t);
        push(3, 2, 0, 4, t);
        wait_to(a + 290);
        expect_cpl(1, a + 251, "R8 first issue");
        expect_cpl(2, a + 261, "R8 spaced 10");
        expect_cpl(3, a + 271, "R8 spaced 20");
        expect_cpl(4, a + 281, "R9 four banks overlap");
    endtask

    task automatic t_same_cycle();
        int a, s, h;
        do_reset();
        push(2, 4, 0, 1, a);
        wait_to(a + 260);
        push(3, 8, 0, 2, s);
        wait_to(s + 199);
        push(2, 4, 7, 3, h);
        chk(h, s + 200, "R11 setup");
        wait_to(s + 260);
        expect_cpl(3, s + 251, "R11 lower bank first");
        expect_cpl(2, s + 252, "R11 higher bank held");
        chk(int'(bank_busy[3:2]), 0, "R11 both released");
    endtask

    task automatic t_full();
        int a, t, f;
        do_reset();
        push(1, 1, 0, 1, a);
        push(1, 1, 1, 2, t);
        push(1, 1, 2, 3, t);
        push(1, 1, 3, 4, t);
        push(1, 1, 4, 5, t);
        chk(int'(req_ready), 0, "R10 ready low when full");
        wait_to(a + 100);
        chk(int'(req_ready), 0, "R10 still full");
        push(1, 1, 5, 6, f);
        chk(f, a + 253, "R10 taken after slot frees");
        wait_to(a + 520);
        expect_cpl(1, a + 251, "R12 tag1");
        expect_cpl(2, a + 302, "R12 tag2");
        expect_cpl(3, a + 353, "R12 tag3");
        expect_cpl(5, a + 455, "R12 tag5");
        expect_cpl(6, a + 506, "R12 tag6");
    endtask

    initial begin
        t_reset();
        t_latency();
        t_hit_first();
        t_oldest();
        t_spacing();
        t_same_cycle();
        t_full();
        summary();
        $finish;
    end
endmodule